// File: doc/BRIEF.md
# Dual-Channel Digital Potentiometer Controller

This block holds the wiper settings of a two-channel, 256-step digital potentiometer and loads them from a three-wire serial port. The port lines are chip select (active low), serial clock and data in. Each write is one 10-bit frame. A 2-bit channel address comes first and the 8-bit wiper code follows it. Both fields are sent most significant bit first. The frame takes effect when chip select returns high. The serial lines are asynchronous to the system clock, so they pass through a synchronizer before edge detection.

An asynchronous active-low clear input forces every wiper latch to the midscale code. An active-low shutdown input makes each channel signal that terminal A is open and that the wiper is tied to terminal B. While shutdown is active, frames still update the latches, and the new codes appear once shutdown is released.

The outputs are the effective wiper code of each channel and the two per-channel switch controls used in shutdown. The analog ladder that these signals drive sits outside the block.

Top module: `dpot_ctrl`

## Requirements
- R1: While `clr_n` is low and after it is released, each channel's latch holds 0x80, and `a_open` and `wiper_to_b` are 0 when `shdn_n` is high.
- R2: A frame is the last 10 bits sampled from `sdi` on rising edges of `sck` while `cs_n` is low, sent MSB first. Bits [9:8] are the address and bits [7:0] are the code. Address 0 selects channel 0, which drives `wiper_eff[7:0]`. Address 1 selects channel 1, which drives `wiper_eff[15:8]`.
- R3: The latch is loaded only on a rising edge of `cs_n`; the outputs do not change while the frame is still being shifted.
- R4: Rising edges of `sck` while `cs_n` is high shift nothing into the frame register.
- R5: Driving `clr_n` low sets both latches to 0x80 at once, without waiting for a clock edge, and also clears the frame register to zero.
- R6: While `shdn_n` is low, every bit of `a_open` and `wiper_to_b` is 1 and each channel's `wiper_eff` is 0.
- R7: Frames received during shutdown are stored in the latches and appear on `wiper_eff` once `shdn_n` returns high.
- R8: A frame whose address is 2 or 3 changes neither latch.
- R9: A transaction with more than 10 clocks keeps only the last 10 bits. A transaction with fewer than 10 clocks combines the newest bits with older bits still in the register.
- R10: When `clr_n` is low at the time a chip-select rising edge is detected, the latches stay at 0x80 and the frame is discarded.
- R11: With SYNC_STAGES = 2, a committed code appears on `wiper_eff` after the third rising edge of `clk` that follows the rise of `cs_n`, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| clr_n | input | 1 | Asynchronous active-low clear; forces midscale |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock; shifts on its rising edge |
| sdi | input | 1 | Serial data in |
| shdn_n | input | 1 | Active-low shutdown |
| wiper_eff | output | NUM_CH*CODE_W | Effective wiper code of each channel, channel 0 in the low bits |
| a_open | output | NUM_CH | Terminal A open-circuit control per channel |
| wiper_to_b | output | NUM_CH | Wiper-to-terminal-B short control per channel |

## Verification
The bench builds the block with its defaults: two channels, an 8-bit code, a 2-bit address and a two-flop synchronizer. With an 8-bit code, the bench can sweep every code value into both channels, using complementary values so that a crossed channel shows up. The 2-bit address lets it apply all four address values, including the two that must be ignored. The short synchronizer keeps each frame to about a hundred clocks, which leaves room to check the commit latency cycle by cycle as well as frames that are too long, too short, sent during shutdown, or overlapped by a clear.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   // Serial and control pins as seen by the synchronizer.
   typedef struct packed {
      logic cs_n;
      logic sck;
      logic sdi;
      logic shdn_n;
   } dpot_pins_t;

   // Idle level of every pin: deselected, clock low, not in shutdown.
   localparam dpot_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0, shdn_n: 1'b1};

   localparam int PIN_W = $bits(dpot_pins_t);

endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int             W       = 4,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("dpot_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("dpot_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/dpot_frame_rx.sv
module dpot_frame_rx #(
   parameter int FRAME_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sck_s,
   input  logic               sdi_s,
   output logic [FRAME_W-1:0] frame,
   output logic               commit
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dpot_frame_rx: FRAME_W must be at least 2");
   end

   logic cs_prev;
   logic sck_prev;
   logic sck_rise;

   assign sck_rise = sck_s & ~sck_prev;
   assign commit   = cs_n_s & ~cs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
      end else begin
         cs_prev  <= cs_n_s;
         sck_prev <= sck_s;
      end
   end

   // Shift register: the oldest bits fall off the top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 frame <= '0;
      else if (sck_rise && !cs_n_s) frame <= {frame[FRAME_W-2:0], sdi_s};
   end

endmodule

// File: rtl/dpot_latch_bank.sv
module dpot_latch_bank #(
   parameter int NUM_CH = 2,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [CODE_W-1:0]        data,
   output logic [NUM_CH-1:0]        we,
   output logic [NUM_CH*CODE_W-1:0] codes
);

   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("dpot_latch_bank: NUM_CH must fit in the address field");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("dpot_latch_bank: CODE_W must be at least 2");
   end

   // Addresses at or above NUM_CH select no channel.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign we[c] = commit && (addr == ADDR_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     codes[c*CODE_W +: CODE_W] <= MID;
         else if (we[c]) codes[c*CODE_W +: CODE_W] <= data;
      end
   end

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
   parameter int NUM_CH      = 2,
   parameter int CODE_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     clr_n,
   input  logic                     cs_n,
   input  logic                     sck,
   input  logic                     sdi,
   input  logic                     shdn_n,
   output logic [NUM_CH*CODE_W-1:0] wiper_eff,
   output logic [NUM_CH-1:0]        a_open,
   output logic [NUM_CH-1:0]        wiper_to_b
);
   import dpot_pkg::*;

   localparam int FRAME_W = ADDR_W + CODE_W;

   dpot_pins_t             pins_raw;
   dpot_pins_t             pins_s;
   logic                   cs_n_s;
   logic                   sck_s;
   logic                   sdi_s;
   logic                   shdn_s;
   logic [FRAME_W-1:0]     frame;
   logic                   commit;
   logic [NUM_CH-1:0]      we;
   logic [NUM_CH*CODE_W-1:0] codes;

   assign pins_raw = '{cs_n: cs_n, sck: sck, sdi: sdi, shdn_n: shdn_n};

   dpot_sync #(
      .W       (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (clr_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign cs_n_s = pins_s.cs_n;
   assign sck_s  = pins_s.sck;
   assign sdi_s  = pins_s.sdi;
   assign shdn_s = pins_s.shdn_n;

   dpot_frame_rx #(
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk    (clk),
      .rst_n  (clr_n),
      .cs_n_s (cs_n_s),
      .sck_s  (sck_s),
      .sdi_s  (sdi_s),
      .frame  (frame),
      .commit (commit)
   );

   dpot_latch_bank #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W),
      .ADDR_W (ADDR_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (clr_n),
      .commit (commit),
      .addr   (frame[FRAME_W-1 -: ADDR_W]),
      .data   (frame[CODE_W-1:0]),
      .we     (we),
      .codes  (codes)
   );

   // Shutdown: the latches keep their codes, but the outputs show terminal A
   // open and the wiper at terminal B (code zero).
   for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      assign a_open[c]     = ~shdn_s;
      assign wiper_to_b[c] = ~shdn_s;
      assign wiper_eff[c*CODE_W +: CODE_W] = shdn_s ? codes[c*CODE_W +: CODE_W] : '0;
   end

endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
   parameter int NUM_CH = 2,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 2
) (
   input logic                        clk,
   input logic                        clr_n,
   input logic                        cs_n_s,
   input logic [ADDR_W+CODE_W-1:0]    frame,
   input logic                        commit,
   input logic [NUM_CH-1:0]           we,
   input logic [NUM_CH*CODE_W-1:0]    codes,
   input logic [NUM_CH*CODE_W-1:0]    wiper_eff,
   input logic [NUM_CH-1:0]           a_open,
   input logic [NUM_CH-1:0]           wiper_to_b
);
   localparam int                FRAME_W = ADDR_W + CODE_W;
   localparam logic [CODE_W-1:0] MID     = {1'b1, {(CODE_W-1){1'b0}}};

   always @(posedge clk) begin
      if (!clr_n) begin
         AST_CLEAR_MIDSCALE: assert (codes == {NUM_CH{MID}}); // R5
      end
   end

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!clr_n)
      $onehot0(we)); // R2

   AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!clr_n)
      !commit |=> $stable(codes)); // R3

   AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!clr_n)
      cs_n_s |=> $stable(frame)); // R4

   AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!clr_n)
      (commit && int'(frame[FRAME_W-1 -: ADDR_W]) >= NUM_CH) |-> (we == '0)); // R8

   for (genvar c = 0; c < NUM_CH; c++) begin : g_shdn
      AST_SHDN_OUTPUTS: assert property (@(posedge clk) disable iff (!clr_n)
         a_open[c] |-> (wiper_to_b[c] && wiper_eff[c*CODE_W +: CODE_W] == '0)); // R6
   end

endmodule

bind dpot_ctrl dpot_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .CODE_W (CODE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .clr_n      (clr_n),
   .cs_n_s     (cs_n_s),
   .frame      (frame),
   .commit     (commit),
   .we         (we),
   .codes      (codes),
   .wiper_eff  (wiper_eff),
   .a_open     (a_open),
   .wiper_to_b (wiper_to_b)
);

// File: tb/sim_dpot_ctrl.sv
`timescale 1ns/1ps
module sim_dpot_ctrl;

   logic        clk = 1'b0;
   logic        clr_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        shdn_n = 1'b1;
   logic [15:0] wiper_eff;
   logic [1:0]  a_open;
   logic [1:0]  wiper_to_b;

   int          vectors = 0;
   int          errs = 0;
   bit          finished = 0;

   logic [9:0]  mdl = '0;
   logic [7:0]  exp_lat [2];
   bit          shut = 0;

   always #4 clk = ~clk;

   dpot_ctrl u0 (
      .clk        (clk),
      .clr_n      (clr_n),
      .cs_n       (cs_n),
      .sck        (sck),
      .sdi        (sdi),
      .shdn_n     (shdn_n),
      .wiper_eff  (wiper_eff),
      .a_open     (a_open),
      .wiper_to_b (wiper_to_b)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag);
      logic [15:0] ew;
      logic [1:0]  eo;
      ew = shut ? 16'h0000 : {exp_lat[1], exp_lat[0]};
      eo = shut ? 2'b11 : 2'b00;
      vectors++;
      if (wiper_eff !== ew || a_open !== eo || wiper_to_b !== eo) begin
         errs++;
         $display("FAIL %s: wiper=%h open=%b tob=%b expected wiper=%h open=%b tob=%b",
                  tag, wiper_eff, a_open, wiper_to_b, ew, eo, eo);
      end
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sck = 1'b0;
         sdi = v[i];
         tick(4);
         sck = 1'b1;
         tick(4);
         if (!cs_n) mdl = {mdl[8:0], v[i]};
      end
      sck = 1'b0;
      tick(4);
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      tick(4);
   endtask

   task automatic cs_rise();
      cs_n = 1'b1;
      tick(6);
      if (mdl[9:8] < 2'd2) exp_lat[mdl[8]] = mdl[7:0];
   endtask

   task automatic frame(input logic [1:0] a, input logic [7:0] d, input string tag);
      cs_low();
      send_bits({6'b0, a, d}, 10);
      check(tag);
      cs_rise();
      check(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: run did not finish, got running expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      exp_lat[0] = 8'h80;
      exp_lat[1] = 8'h80;
      #2 clr_n = 1'b0;
      tick(3);
      check("R1 midscale during clear");
      clr_n = 1'b1;
      tick(4);
      check("R1 midscale after clear");

      // R11: commit latency through a two-stage synchronizer
      cs_low();
      send_bits({6'b0, 2'b00, 8'h40}, 10);
      cs_n = 1'b1;
      tick(2);
      check("R11 not yet after two edges");
      tick(1);
      exp_lat[0] = mdl[7:0];
      check("R11 visible after third edge");
      tick(3);

      // R2 R3: full code sweep on both channels
      for (int d = 0; d < 256; d++) begin
         frame(2'b00, 8'(d), "R2 R3 sweep ch0");
         frame(2'b01, 8'(255 - d), "R2 R3 sweep ch1");
      end

      // R8: out-of-range addresses
      frame(2'b10, 8'h77, "R8 address 2 ignored");
      frame(2'b11, 8'h99, "R8 address 3 ignored");

      // R4 and short frame R9
      frame(2'b00, 8'h25, "R4 setup");
      send_bits(16'h03FF, 10);
      check("R4 clocks while deselected");
      cs_low();
      send_bits(16'h0001, 1);
      cs_rise();
      check("R4 R9 short frame reuses old bits");

      // R9: overlength frame keeps last ten bits
      cs_low();
      send_bits({3'b0, 3'b101, 2'b01, 8'hC3}, 13);
      cs_rise();
      check("R9 overlength frame");

      // R6 R7: shutdown
      shdn_n = 1'b0;
      tick(4);
      shut = 1;
      check("R6 shutdown outputs");
      frame(2'b01, 8'h5E, "R7 write during shutdown");
      frame(2'b00, 8'h13, "R7 write during shutdown");
      shdn_n = 1'b1;
      tick(4);
      shut = 0;
      check("R7 codes after shutdown release");

      // R5: asynchronous clear mid-operation
      clr_n = 1'b0;
      #1;
      exp_lat[0] = 8'h80;
      exp_lat[1] = 8'h80;
      mdl = '0;
      check("R5 immediate midscale");
      tick(3);
      clr_n = 1'b1;
      tick(4);
      check("R5 midscale held after release");
      cs_low();
      cs_rise();
      check("R5 frame register cleared");

      // R10: clear overlapping a commit
      frame(2'b01, 8'h3A, "R10 setup");
      cs_low();
      send_bits({6'b0, 2'b00, 8'h11}, 10);
      cs_n = 1'b1;
      clr_n = 1'b0;
      tick(6);
      exp_lat[0] = 8'h80;
      exp_lat[1] = 8'h80;
      mdl = '0;
      clr_n = 1'b1;
      tick(4);
      check("R10 clear wins over commit");

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule